// File: doc/BRIEF.md
# Bit-Serial Shift-Register Cell Switch

This block is the core of a small N-by-N cell switch. Each input port receives a cell one bit per clock and writes it into one of several per-input shift registers, each large enough for exactly one cell. Cells stay serial for their whole stay in the switch. Nothing converts them to a parallel word.

When an input finishes storing a cell, it announces the cell's buffer location on a shared address bus. The location is the input number plus the register number. The cell's destination bitmap selects which output queues capture that announcement, and all selected queues capture it in the same clock. This is how one stored cell reaches several outputs.

Each output drains its own queue of locations in arrival order. It reads the selected register through its own read tap, one bit per clock, onto its own output line. A register goes back to the free pool only after every output that was sent the cell has finished reading it. If an input has no free register when a cell begins, the cell is discarded and a per-input discard counter is incremented.

Top module: `srsw_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, every `out_valid` bit is 0 and every discard counter reads 0.
- R2: A cell is `CELL_BITS` bits long and arrives on consecutive clocks. Its first bit is presented together with `in_start`, and the destination bitmap is sampled in that same clock. Bit k of input i's bitmap (`in_dest[i*N+k]`) selects output k. Every cell that is stored comes out unchanged, first bit first.
- R3: When the address bus is uncontended and the output is idle, the first bit of a stored cell appears on each selected output, with `out_valid` high, exactly `CELL_BITS`+2 clocks after the clock carrying its start strobe.
- R4: The address bus carries at most one announcement per clock. Every output selected by the cell's bitmap captures that announcement in the same clock, and outputs not selected receive nothing.
- R5: When several inputs have announcements waiting, the bus is granted round-robin. The search starts at the input after the one most recently granted, and at input 0 after reset. A waiting input keeps its request until it is granted.
- R6: Each output sends its cells in the order their announcements reached it. When its queue is not empty, the next cell starts in the clock right after the previous cell's last bit.
- R7: No output queue is ever written while it already holds `N*K` entries.
- R8: A cell sent to several outputs is delivered intact to every one of them. Its register is not reused while any selected output has yet to finish reading it.
- R9: If every register of an input is in use when `in_start` arrives, that cell is discarded and its bits are ignored. The input's discard counter (`drop_cnt[i*CW +: CW]`) increments by one, modulo 2^CW. Other inputs are unaffected.
- R10: Registers freed by the outputs are allocated again, so an input that discarded a cell accepts and delivers later cells once its backlog has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_bit | input | N | Serial cell data, one bit per input |
| in_start | input | N | Start-of-cell strobe, one per input, high with the first bit |
| in_dest | input | N*N | Destination bitmap per input; field i at bits [i*N +: N] |
| out_bit | output | N | Serial cell data, one bit per output |
| out_valid | output | N | High while the matching output line carries cell bits |
| drop_cnt | output | N*CW | Per-input discard counters; field i at bits [i*CW +: CW] |

## Verification
The bound assertions check four things on every clock: bus grants are one-hot and only go to requesting inputs, a waiting request is held until it is granted, no output queue is written while full, and a discard counter only ever moves by one in response to a start strobe. Several behaviours can only be shown by the bench scenarios, because each one spans a whole cell or compares several cells: bit-exact delivery, the fixed latency, the order produced by a simultaneous four-way contest, gap-free back-to-back output, discarding when an input runs out of registers, and protection of a multicast register while a delayed reader is still draining it.

// File: rtl/srsw_pkg.sv
package srsw_pkg;

    // Number of set bits in a word; used to size a register's pending-copy count.
    function automatic int unsigned ones_of(input logic [31:0] v);
        int unsigned c;
        c = 0;
        for (int b = 0; b < 32; b++) begin
            if (v[b]) c++;
        end
        return c;
    endfunction

endpackage

// File: rtl/srsw_in_bank.sv
module srsw_in_bank
    import srsw_pkg::*;
#(
    parameter int N  = 4,
    parameter int K  = 4,
    parameter int L  = 424,
    parameter int CW = 8,
    parameter int ID = 0,
    localparam int INW  = $clog2(N),
    localparam int KW   = $clog2(K),
    localparam int PW   = $clog2(L),
    localparam int CNTW = $clog2(N + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_bit,
    input  logic                     in_start,
    input  logic [N-1:0]             in_dest,
    input  logic                     grant,
    input  logic [N-1:0][INW-1:0]    rd_in,
    input  logic [N-1:0][KW-1:0]     rd_reg,
    input  logic [N-1:0][PW-1:0]     rd_pos,
    input  logic [N-1:0]             rel,
    output logic                     req,
    output logic [KW-1:0]            req_reg,
    output logic [N-1:0]             req_dest,
    output logic [N-1:0]             tap,
    output logic [CW-1:0]            drops
);

    typedef struct packed {
        logic [K-1:0][L-1:0]    mem;
        logic [K-1:0][CNTW-1:0] cnt;
        logic                   fill;
        logic [KW-1:0]          freg;
        logic [PW-1:0]          fpos;
        logic [N-1:0]           fdest;
        logic                   req;
        logic [KW-1:0]          rreg;
        logic [N-1:0]           rdest;
        logic [CW-1:0]          drops;
    } bank_t;

    bank_t s_q, s_d;
    logic            free_ok;
    logic [KW-1:0]   free_idx;
    logic [CNTW-1:0] dec;

    always_comb begin
        s_d      = s_q;
        free_ok  = 1'b0;
        free_idx = '0;
        dec      = '0;

        // lowest-numbered register with no outstanding copies
        for (int r = K - 1; r >= 0; r--) begin
            if (s_q.cnt[r] == '0) begin
                free_ok  = 1'b1;
                free_idx = KW'(r);
            end
        end

        // outputs finishing a read of one of our registers
        for (int r = 0; r < K; r++) begin
            dec = '0;
            for (int k = 0; k < N; k++) begin
                if (rel[k] && rd_in[k] == INW'(ID) && rd_reg[k] == KW'(r))
                    dec = dec + CNTW'(1);
            end
            s_d.cnt[r] = s_q.cnt[r] - dec;
        end

        if (grant) s_d.req = 1'b0;

        if (s_q.fill) begin
            s_d.mem[s_q.freg] = {s_q.mem[s_q.freg][L-2:0], in_bit};
            if (s_q.fpos == PW'(L - 1)) begin
                s_d.fill  = 1'b0;
                s_d.req   = 1'b1;
                s_d.rreg  = s_q.freg;
                s_d.rdest = s_q.fdest;
            end else begin
                s_d.fpos = s_q.fpos + PW'(1);
            end
        end else if (in_start) begin
            if (free_ok) begin
                s_d.fill           = 1'b1;
                s_d.freg           = free_idx;
                s_d.fpos           = PW'(1);
                s_d.fdest          = in_dest;
                s_d.mem[free_idx]  = {s_q.mem[free_idx][L-2:0], in_bit};
                s_d.cnt[free_idx]  = CNTW'(ones_of(32'(in_dest)));
            end else begin
                s_d.drops = s_q.drops + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // one independent read tap per output; first bit received sits at L-1
    always_comb begin
        for (int k = 0; k < N; k++) begin
            tap[k] = s_q.mem[rd_reg[k]][PW'(L - 1) - rd_pos[k]];
        end
    end

    assign req      = s_q.req;
    assign req_reg  = s_q.rreg;
    assign req_dest = s_q.rdest;
    assign drops    = s_q.drops;

endmodule

// File: rtl/srsw_rr_arb.sv
module srsw_rr_arb #(
    parameter int N = 4,
    localparam int INW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   req,
    output logic [N-1:0]   grant,
    output logic [INW-1:0] gidx,
    output logic           gvalid
);

    typedef struct packed {
        logic [INW-1:0] ptr;
    } arb_t;

    arb_t s_q, s_d;

    always_comb begin
        int t;
        s_d    = s_q;
        gvalid = 1'b0;
        gidx   = '0;
        // scan downward so the smallest offset from the pointer wins
        for (int o = N - 1; o >= 0; o--) begin
            t = int'(s_q.ptr) + o;
            if (t >= N) t = t - N;
            if (req[t]) begin
                gvalid = 1'b1;
                gidx   = INW'(t);
            end
        end
        grant = gvalid ? (N'(1) << gidx) : '0;
        if (gvalid) begin
            s_d.ptr = (gidx == INW'(N - 1)) ? '0 : gidx + INW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/srsw_out_port.sv
module srsw_out_port #(
    parameter int N = 4,
    parameter int K = 4,
    parameter int L = 424,
    localparam int INW = $clog2(N),
    localparam int KW  = $clog2(K),
    localparam int PW  = $clog2(L),
    localparam int AW  = INW + KW,
    localparam int D   = N * K,
    localparam int FAW = $clog2(D),
    localparam int QW  = $clog2(D + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [AW-1:0]  push_addr,
    output logic           busy,
    output logic [INW-1:0] rd_in,
    output logic [KW-1:0]  rd_reg,
    output logic [PW-1:0]  rd_pos,
    output logic           rel,
    output logic [QW-1:0]  qcnt
);

    typedef struct packed {
        logic [D-1:0][AW-1:0] fifo;
        logic [FAW-1:0]       wp;
        logic [FAW-1:0]       rp;
        logic [QW-1:0]        cnt;
        logic                 busy;
        logic [AW-1:0]        cur;
        logic [PW-1:0]        pos;
    } port_t;

    port_t s_q, s_d;
    logic  last;
    logic  pop;

    always_comb begin
        s_d  = s_q;
        last = s_q.busy && (s_q.pos == PW'(L - 1));
        pop  = (!s_q.busy || last) && (s_q.cnt != '0);

        if (push) begin
            s_d.fifo[s_q.wp] = push_addr;
            s_d.wp = (s_q.wp == FAW'(D - 1)) ? '0 : s_q.wp + FAW'(1);
        end

        if (pop) begin
            s_d.cur  = s_q.fifo[s_q.rp];
            s_d.rp   = (s_q.rp == FAW'(D - 1)) ? '0 : s_q.rp + FAW'(1);
            s_d.busy = 1'b1;
            s_d.pos  = '0;
        end else if (last) begin
            s_d.busy = 1'b0;
            s_d.pos  = '0;
        end else if (s_q.busy) begin
            s_d.pos = s_q.pos + PW'(1);
        end

        s_d.cnt = s_q.cnt + QW'(push) - QW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy   = s_q.busy;
    assign rd_in  = s_q.cur[AW-1:KW];
    assign rd_reg = s_q.cur[KW-1:0];
    assign rd_pos = s_q.pos;
    assign rel    = last;
    assign qcnt   = s_q.cnt;

endmodule

// File: rtl/srsw_top.sv
module srsw_top #(
    parameter int N         = 4,
    parameter int K         = 4,
    parameter int CELL_BITS = 424,
    parameter int CW        = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    in_bit,
    input  logic [N-1:0]    in_start,
    input  logic [N*N-1:0]  in_dest,
    output logic [N-1:0]    out_bit,
    output logic [N-1:0]    out_valid,
    output logic [N*CW-1:0] drop_cnt
);

    localparam int INW = $clog2(N);
    localparam int KW  = $clog2(K);
    localparam int PW  = $clog2(CELL_BITS);
    localparam int AW  = INW + KW;
    localparam int QW  = $clog2(N * K + 1);

    logic [N-1:0]            bank_req;
    logic [N-1:0][KW-1:0]    bank_reg;
    logic [N-1:0][N-1:0]     bank_dest;
    logic [N-1:0][N-1:0]     bank_tap;
    logic [N-1:0]            grant;
    logic [INW-1:0]          gidx;
    logic                    gvalid;
    logic [N-1:0][INW-1:0]   rd_in;
    logic [N-1:0][KW-1:0]    rd_reg;
    logic [N-1:0][PW-1:0]    rd_pos;
    logic [N-1:0]            rel;
    logic [N-1:0]            push;
    logic [N-1:0][QW-1:0]    qcnt;
    logic [AW-1:0]           bus_addr;
    logic [N-1:0]            bus_sel;

    srsw_rr_arb #(.N(N)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (bank_req),
        .grant  (grant),
        .gidx   (gidx),
        .gvalid (gvalid)
    );

    // shared address bus and selection bus
    assign bus_addr = {gidx, bank_reg[gidx]};
    assign bus_sel  = gvalid ? bank_dest[gidx] : '0;
    assign push     = bus_sel;

    for (genvar i = 0; i < N; i++) begin : g_in
        srsw_in_bank #(.N(N), .K(K), .L(CELL_BITS), .CW(CW), .ID(i)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_bit   (in_bit[i]),
            .in_start (in_start[i]),
            .in_dest  (in_dest[i*N +: N]),
            .grant    (grant[i]),
            .rd_in    (rd_in),
            .rd_reg   (rd_reg),
            .rd_pos   (rd_pos),
            .rel      (rel),
            .req      (bank_req[i]),
            .req_reg  (bank_reg[i]),
            .req_dest (bank_dest[i]),
            .tap      (bank_tap[i]),
            .drops    (drop_cnt[i*CW +: CW])
        );
    end

    for (genvar k = 0; k < N; k++) begin : g_out
        srsw_out_port #(.N(N), .K(K), .L(CELL_BITS)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push[k]),
            .push_addr (bus_addr),
            .busy      (out_valid[k]),
            .rd_in     (rd_in[k]),
            .rd_reg    (rd_reg[k]),
            .rd_pos    (rd_pos[k]),
            .rel       (rel[k]),
            .qcnt      (qcnt[k])
        );
        // output line k carries the tap of the input its reader has selected
        assign out_bit[k] = out_valid[k] & bank_tap[rd_in[k]][k];
    end

endmodule

// File: rtl/srsw_checker.sv
module srsw_checker #(
    parameter int N  = 4,
    parameter int K  = 4,
    parameter int CW = 8,
    localparam int D  = N * K,
    localparam int QW = $clog2(D + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N-1:0]          in_start,
    input logic [N-1:0]          req_w,
    input logic [N-1:0]          grant_w,
    input logic [N-1:0]          push_w,
    input logic [N-1:0][QW-1:0]  qcnt_w,
    input logic [N*CW-1:0]       drop_w
);

    // R4: one announcement per clock on the address bus
    assert_bus_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_w));

    // R5: grants only go to inputs that are asking
    assert_grant_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_w & ~req_w) == '0);

    for (genvar i = 0; i < N; i++) begin : g_in_chk
        // R5: a waiting request is kept until granted
        assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (req_w[i] && !grant_w[i]) |=> req_w[i]);

        // R9: discard counter only steps by one, after a start strobe
        assert_drop_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (drop_w[i*CW +: CW] != $past(drop_w[i*CW +: CW])) |->
            ($past(in_start[i]) && drop_w[i*CW +: CW] == $past(drop_w[i*CW +: CW]) + CW'(1)));
    end

    for (genvar k = 0; k < N; k++) begin : g_out_chk
        // R7: a queue is never written when it is already full
        assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
            push_w[k] |-> (qcnt_w[k] < QW'(D)));
    end

endmodule

bind srsw_top srsw_checker #(.N(N), .K(K), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_start (in_start),
    .req_w    (bank_req),
    .grant_w  (grant),
    .push_w   (push),
    .qcnt_w   (qcnt),
    .drop_w   (drop_cnt)
);

// File: tb/sim_srsw_top.sv
module sim_srsw_top;

    localparam int N  = 4;
    localparam int K  = 4;
    localparam int L  = 8;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0]    in_bit   = '0;
    logic [N-1:0]    in_start = '0;
    logic [N*N-1:0]  in_dest  = '0;
    logic [N-1:0]    out_bit;
    logic [N-1:0]    out_valid;
    logic [N*CW-1:0] drop_cnt;

    srsw_top #(.N(N), .K(K), .CELL_BITS(L), .CW(CW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_bit    (in_bit),
        .in_start  (in_start),
        .in_dest   (in_dest),
        .out_bit   (out_bit),
        .out_valid (out_valid),
        .drop_cnt  (drop_cnt)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // output monitor: rebuilds cells of L bits and the cycle of their first bit
    logic [L-1:0] rec   [N][64];
    int           rec_t [N][64];
    int           nrec  [N];
    logic [L-1:0] sh    [N];
    int           bc    [N];
    int           t0    [N];

    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < N; k++) begin
                if (out_valid[k]) begin
                    if (bc[k] == 0) t0[k] = cyc;
                    sh[k] = {sh[k][L-2:0], out_bit[k]};
                    bc[k] = bc[k] + 1;
                    if (bc[k] == L) begin
                        if (nrec[k] < 64) begin
                            rec[k][nrec[k]]   = sh[k];
                            rec_t[k][nrec[k]] = t0[k];
                        end
                        nrec[k] = nrec[k] + 1;
                        bc[k]   = 0;
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send_one(input int i, input logic [N-1:0] dst, input logic [L-1:0] pl,
                            output int sc);
        for (int b = 0; b < L; b++) begin
            @(negedge clk);
            if (b == 0) begin
                sc = cyc;
                in_start[i] = 1'b1;
                in_dest[i*N +: N] = dst;
            end else begin
                in_start[i] = 1'b0;
            end
            in_bit[i] = pl[L-1-b];
        end
    endtask

    // stimulus table: [13:12] input, [11:8] destination bitmap, [7:0] payload
    localparam logic [13:0] VEC [8] = '{
        {2'd0, 4'b0001, 8'hA5},
        {2'd1, 4'b0010, 8'h3C},
        {2'd2, 4'b0100, 8'hF0},
        {2'd3, 4'b1000, 8'h0F},
        {2'd0, 4'b0110, 8'h81},
        {2'd2, 4'b1001, 8'h7E},
        {2'd3, 4'b0011, 8'hC3},
        {2'd1, 4'b1111, 8'h5A}
    };

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R6 watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int last_g;
        int base [N];
        int sc, sc2, sc3;

        // R1: reset state, during and just after reset
        repeat (4) @(negedge clk);
        check(out_valid == '0, "R1 valid in reset", int'(out_valid), 0);
        check(drop_cnt == '0, "R1 drops in reset", int'(drop_cnt), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == '0, "R1 valid after reset", int'(out_valid), 0);
        check(drop_cnt == '0, "R1 drops after reset", int'(drop_cnt), 0);

        // table walk: isolated cells, unicast and multicast
        last_g = 0;
        for (int v = 0; v < 8; v++) begin
            int            vi;
            logic [N-1:0]  vd;
            logic [L-1:0]  vp;
            vi = int'(VEC[v][13:12]);
            vd = VEC[v][11:8];
            vp = VEC[v][7:0];
            for (int k = 0; k < N; k++) base[k] = nrec[k];
            send_one(vi, vd, vp, sc);
            repeat (L + 6) @(negedge clk);
            for (int k = 0; k < N; k++) begin
                if (vd[k]) begin
                    check(nrec[k] == base[k] + 1, "R4 selected output count", nrec[k], base[k] + 1);
                    check(rec[k][base[k]] == vp, vd == 4'b1111 ? "R8 multicast data" : "R2 cell data",
                          int'(rec[k][base[k]]), int'(vp));
                    check(rec_t[k][base[k]] == sc + L + 2, "R3 latency",
                          rec_t[k][base[k]], sc + L + 2);
                end else begin
                    check(nrec[k] == base[k], "R4 unselected output", nrec[k], base[k]);
                end
            end
            last_g = vi;
        end

        // R5/R6: all inputs finish together, all to output 0
        base[0] = nrec[0];
        fork
            begin int s; send_one(0, 4'b0001, 8'h10, s); sc = s; end
            begin int s; send_one(1, 4'b0001, 8'h11, s); end
            begin int s; send_one(2, 4'b0001, 8'h12, s); end
            begin int s; send_one(3, 4'b0001, 8'h13, s); end
        join
        repeat (6 * L) @(negedge clk);
        check(nrec[0] == base[0] + 4, "R6 contention count", nrec[0], base[0] + 4);
        for (int j = 0; j < 4; j++) begin
            int o;
            o = (last_g + 1 + j) % N;
            check(rec[0][base[0] + j] == 8'(8'h10 + o), "R5 round-robin order",
                  int'(rec[0][base[0] + j]), 8'h10 + o);
            check(rec_t[0][base[0] + j] == sc + L + 2 + j * L, "R6 back-to-back timing",
                  rec_t[0][base[0] + j], sc + L + 2 + j * L);
        end

        // R9/R7: input 0 runs out of registers behind a backlog at output 0
        for (int k = 0; k < N; k++) base[k] = nrec[k];
        fork
            begin for (int s = 0; s < 4; s++) begin int t; send_one(1, 4'b0001, 8'(8'h90 + s), t); end end
            begin for (int s = 0; s < 4; s++) begin int t; send_one(2, 4'b0001, 8'(8'hA0 + s), t); end end
            begin for (int s = 0; s < 4; s++) begin int t; send_one(3, 4'b0001, 8'(8'hB0 + s), t); end end
            begin
                repeat (L) @(negedge clk);
                for (int s = 0; s < 5; s++) begin int t; send_one(0, 4'b0001, 8'(8'h80 + s), t); end
            end
        join
        repeat (20 * L + 20) @(negedge clk);
        check(drop_cnt[CW-1:0] == 8'd1, "R9 discard count input 0", int'(drop_cnt[CW-1:0]), 1);
        check(drop_cnt[N*CW-1:CW] == '0, "R9 other inputs untouched", int'(drop_cnt[N*CW-1:CW]), 0);
        check(nrec[0] == base[0] + 16, "R7 cells delivered under backlog", nrec[0], base[0] + 16);
        begin
            int seen84;
            int nxt;
            seen84 = 0;
            nxt = 0;
            for (int j = base[0]; j < nrec[0] && j < 64; j++) begin
                if (rec[0][j] == 8'h84) seen84++;
                if (rec[0][j][7:4] == 4'h8) begin
                    check(rec[0][j] == 8'(8'h80 + nxt), "R6 per-input order kept",
                          int'(rec[0][j]), 8'h80 + nxt);
                    nxt++;
                end
            end
            check(seen84 == 0, "R9 discarded cell absent", seen84, 0);
        end
        for (int k = 1; k < N; k++)
            check(nrec[k] == base[k], "R4 no stray delivery", nrec[k], base[k]);

        // R10: input 0 accepts again after the backlog drained
        base[2] = nrec[2];
        send_one(0, 4'b0100, 8'hE7, sc);
        repeat (L + 6) @(negedge clk);
        check(nrec[2] == base[2] + 1, "R10 reuse count", nrec[2], base[2] + 1);
        check(rec[2][base[2]] == 8'hE7, "R10 reuse data", int'(rec[2][base[2]]), 8'hE7);
        check(rec_t[2][base[2]] == sc + L + 2, "R10 reuse latency", rec_t[2][base[2]], sc + L + 2);

        // R8: multicast register must survive a late reader on output 3
        for (int k = 0; k < N; k++) base[k] = nrec[k];
        fork
            begin int s; send_one(2, 4'b1000, 8'h3D, s); end
            begin
                @(negedge clk);
                send_one(1, 4'b1001, 8'hB6, sc2);
                repeat (L + 3) @(negedge clk);
                send_one(1, 4'b0010, 8'h6C, sc3);
            end
        join
        repeat (3 * L + 10) @(negedge clk);
        check(rec[0][base[0]] == 8'hB6, "R8 early reader data", int'(rec[0][base[0]]), 8'hB6);
        check(rec[3][base[3]] == 8'h3D, "R8 late port first cell", int'(rec[3][base[3]]), 8'h3D);
        check(rec[3][base[3] + 1] == 8'hB6, "R8 late reader data", int'(rec[3][base[3] + 1]), 8'hB6);
        check(rec[1][base[1]] == 8'h6C, "R8 following cell data", int'(rec[1][base[1]]), 8'h6C);
        check(nrec[3] == base[3] + 2, "R8 late port count", nrec[3], base[3] + 2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule